// File: doc/BRIEF.md
# Quarter-Rate Downconverter Front End

This block is the first part of a digital downconverter. It takes 14-bit signed real samples from a converter that bandpass-samples an intermediate frequency. An optional oscillator mixes the band centre down to zero. The mixer reads only the top two bits of a 32-bit phase accumulator, so no multipliers are needed. At a tuning word of 0x40000000 (fs/4) this mixing is exact. A 19-tap half-band low-pass filter follows, which is always in the path and decimates by two. After it comes a registered slot that stands in for a channel filter. A last optional stage rotates the result up to one eighth of the input rate and gives a real signal again.

Five routings are chosen with a mode code. The mode and the tuning word are taken in only on a synchronous clear. The clear also empties the delay lines and restarts the phase, decimation and rotation counters. Samples come in on a valid/ready stream and results leave on a second one. Back-pressure stalls the whole pipeline. While the single output register holds a result that has not been taken, no new sample is accepted. No sample is lost and none is duplicated.

Top module: `ddc_front`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. In the cycle after a `clear`, `out_valid` is 0 and the sample count, phase, delay lines, channel slot and rotation counter all restart from zero.
- R2: `mode` and `freq_word` are latched only while `clear` is high; changing them at any other time has no effect on the output. Out of reset the latched mode is 0 and the word is 0.
- R3: In modes 2, 3 and 4 the k-th accepted sample after a clear (k from 0) is mixed according to q = bits [31:30] of k·word mod 2^32: q=0 gives (I,Q)=(x,0), q=1 gives (0,−x), q=2 gives (−x,0), q=3 gives (0,x). In modes 0 and 1 the result is (x,0).
- R4: The half-band filter has 19 taps with integer coefficients over a scale of 65536. The centre tap is 32768. Taps at odd distances 1, 3, 5, 7 and 9 from the centre are 20000, −5400, 2300, −800 and 284. Taps at even distances are zero. The output is floor(Σ h·x / 65536), with x the mixed samples, newest first.
- R5: In modes 0 and 2, a result is produced on accepted samples n = 19, 21, 23, … (counted from 1 after a clear), and never on others.
- R6: In modes 1, 3 and 4 the channel slot delays the results by one decimated sample. The first result appears on sample 21 and carries the filter value computed at sample 19.
- R7: In mode 4 the m-th emitted result (m from 0 after a clear) is real and equals I, −Q, −I, Q for m mod 4 = 0, 1, 2, 3.
- R8: Modes 0, 1 and 4 give real output: `out_q` is 0 and `out_i` carries the value. Modes 2 and 3 give I on `out_i` and Q on `out_q`.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` low, `out_valid`, `out_i` and `out_q` stay unchanged. A sample is taken only when `in_valid` and `in_ready` are both high and `clear` is low.
- R10: Mode codes 5, 6 and 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear; latches mode and word |
| mode | input | 3 | Routing code, latched on clear |
| freq_word | input | 32 | Oscillator tuning word, latched on clear |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 14 | Signed real input sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_i | output | 16 | Signed in-phase or real result |
| out_q | output | 16 | Signed quadrature result, 0 in real modes |

## Verification
The bench targets the fill boundary. A block that emits on sample 18 or 20, or that lets the channel slot release its zero reset value, shows up as a count or data mismatch on short runs of 18 and 20 samples. Full-scale inputs of −8192 and 8191 under quarter-rate mixing catch a mixer that overflows when it negates. A wrong sign or swap pattern, or a rotation counter that does not restart on clear, corrupts every second or fourth complex and eighth-rate result. Random stalls on both sides expose a pipeline that drops or repeats a sample under back-pressure. A mode change made without a clear exposes a block that reads its configuration live.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int NTAPS      = 19;
  localparam int CTR        = (NTAPS - 1) / 2;
  localparam int COEF_W     = 18;
  localparam int COEF_SHIFT = 16;

  typedef enum logic [2:0] {
    M_HB         = 3'd0,
    M_HB_FIR     = 3'd1,
    M_OSC_HB     = 3'd2,
    M_OSC_HB_FIR = 3'd3,
    M_FULL       = 3'd4
  } route_e;

  // half-band tap k (0..NTAPS-1); scale 2^COEF_SHIFT
  function automatic logic signed [COEF_W-1:0] hb_coef(input int k);
    int d;
    d = (k > CTR) ? k - CTR : CTR - k;
    case (d)
      0:       return COEF_W'(32768);
      1:       return COEF_W'(20000);
      3:       return -COEF_W'(5400);
      5:       return COEF_W'(2300);
      7:       return -COEF_W'(800);
      9:       return COEF_W'(284);
      default: return '0;
    endcase
  endfunction

  function automatic route_e sanitize(input logic [2:0] code);
    return (code > 3'd4) ? M_HB : route_e'(code);
  endfunction

  function automatic logic uses_osc(input route_e r);
    return (r == M_OSC_HB) || (r == M_OSC_HB_FIR) || (r == M_FULL);
  endfunction

  function automatic logic uses_fir(input route_e r);
    return (r == M_HB_FIR) || (r == M_OSC_HB_FIR) || (r == M_FULL);
  endfunction

  function automatic logic is_real(input route_e r);
    return (r == M_HB) || (r == M_HB_FIR) || (r == M_FULL);
  endfunction
endpackage

// File: rtl/ddc_nco_mixer.sv
module ddc_nco_mixer #(
  parameter int IN_W  = 14,
  parameter int PH_W  = 32,
  parameter int MIX_W = IN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic                    osc_en,
  input  logic [PH_W-1:0]         word,
  input  logic signed [IN_W-1:0]  x,
  output logic signed [MIX_W-1:0] mix_i,
  output logic signed [MIX_W-1:0] mix_q
);
  logic [PH_W-1:0]         phase;
  logic [1:0]              quad;
  logic signed [MIX_W-1:0] xe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (clear)  phase <= '0;
    else if (step)   phase <= phase + word;
  end

  assign quad = osc_en ? phase[PH_W-1 -: 2] : 2'd0;
  assign xe   = MIX_W'(x);

  always_comb begin
    case (quad)
      2'd0:    begin mix_i = xe;  mix_q = '0;  end
      2'd1:    begin mix_i = '0;  mix_q = -xe; end
      2'd2:    begin mix_i = -xe; mix_q = '0;  end
      default: begin mix_i = '0;  mix_q = xe;  end
    endcase
  end

  // R3
  osc_one_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mix_i != '0, mix_q != '0}));
endmodule

// File: rtl/ddc_hb_decim.sv
module ddc_hb_decim
  import ddc_pkg::*;
#(
  parameter int DW    = 15,
  parameter int OW    = 16,
  parameter int ACC_W = DW + COEF_W + 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic signed [OW-1:0] y_i,
  output logic signed [OW-1:0] y_q,
  output logic                 hb_evt,
  output logic                 late_ok
);
  localparam int PAIRS = (NTAPS + 1) / 4;
  localparam int LIMIT = NTAPS + 2;
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic signed [DW-1:0]    ti  [NTAPS];
  logic signed [DW-1:0]    tq  [NTAPS];
  logic signed [DW-1:0]    ni  [NTAPS];
  logic signed [DW-1:0]    nq  [NTAPS];
  logic signed [ACC_W-1:0] pi_ [PAIRS];
  logic signed [ACC_W-1:0] pq_ [PAIRS];
  logic signed [ACC_W-1:0] acc_i, acc_q;
  logic [CNT_W-1:0]        cnt, cnt_nx;
  logic                    par;

  always_comb begin
    ni[0] = in_i;
    nq[0] = in_q;
    for (int k = 1; k < NTAPS; k++) begin
      ni[k] = ti[k-1];
      nq[k] = tq[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) begin ti[k] <= '0; tq[k] <= '0; end
    end else if (clear) begin
      for (int k = 0; k < NTAPS; k++) begin ti[k] <= '0; tq[k] <= '0; end
    end else if (step) begin
      for (int k = 0; k < NTAPS; k++) begin ti[k] <= ni[k]; tq[k] <= nq[k]; end
    end
  end

  // symmetric pairs at odd distance from the centre; even ones are zero
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int D = 2 * p + 1;
    localparam logic signed [COEF_W-1:0] C = hb_coef(CTR + D);
    logic signed [DW:0] si, sq;
    assign si     = (DW+1)'(ni[CTR-D]) + (DW+1)'(ni[CTR+D]);
    assign sq     = (DW+1)'(nq[CTR-D]) + (DW+1)'(nq[CTR+D]);
    assign pi_[p] = ACC_W'(si) * ACC_W'(C);
    assign pq_[p] = ACC_W'(sq) * ACC_W'(C);
  end

  always_comb begin
    acc_i = ACC_W'(ni[CTR]) <<< (COEF_SHIFT - 1);
    acc_q = ACC_W'(nq[CTR]) <<< (COEF_SHIFT - 1);
    for (int p = 0; p < PAIRS; p++) begin
      acc_i = acc_i + pi_[p];
      acc_q = acc_q + pq_[p];
    end
  end

  assign y_i = OW'(acc_i >>> COEF_SHIFT);
  assign y_q = OW'(acc_q >>> COEF_SHIFT);

  assign cnt_nx  = (cnt == CNT_W'(LIMIT)) ? cnt : cnt + 1'b1;
  assign hb_evt  = step && (cnt_nx >= CNT_W'(NTAPS)) && !par;
  assign late_ok = cnt_nx >= CNT_W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      par <= 1'b0;
    end else if (clear) begin
      cnt <= '0;
      par <= 1'b0;
    end else if (step) begin
      cnt <= cnt_nx;
      par <= ~par;
    end
  end

  // R5
  dec_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_evt && !clear) |=> !hb_evt);
endmodule

// File: rtl/ddc_out_stage.sv
module ddc_out_stage #(
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 hb_evt,
  input  logic                 late_ok,
  input  logic                 fir_en,
  input  logic                 fs8_en,
  input  logic                 real_en,
  input  logic signed [OW-1:0] y_i,
  input  logic signed [OW-1:0] y_q,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);
  logic signed [OW-1:0] fir_i, fir_q, src_i, src_q, nx_i, nx_q;
  logic [1:0]           rot;
  logic                 emit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fir_i <= '0;
      fir_q <= '0;
    end else if (clear) begin
      fir_i <= '0;
      fir_q <= '0;
    end else if (hb_evt && fir_en) begin
      fir_i <= y_i;
      fir_q <= y_q;
    end
  end

  assign emit  = hb_evt && (!fir_en || late_ok);
  assign src_i = fir_en ? fir_i : y_i;
  assign src_q = fir_en ? fir_q : y_q;

  always_comb begin
    if (fs8_en) begin
      nx_q = '0;
      case (rot)
        2'd0:    nx_i = src_i;
        2'd1:    nx_i = -src_q;
        2'd2:    nx_i = -src_i;
        default: nx_i = src_q;
      endcase
    end else begin
      nx_i = src_i;
      nx_q = real_en ? '0 : src_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot       <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (clear) begin
      rot       <= '0;
      out_valid <= 1'b0;
    end else if (emit) begin
      rot       <= rot + 1'b1;
      out_valid <= 1'b1;
      out_i     <= nx_i;
      out_q     <= nx_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  clear_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear) |=>
      (out_valid && $stable(out_i) && $stable(out_q)));

  // R8
  real_q_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && real_en) |-> (out_q == '0));
endmodule

// File: rtl/ddc_front.sv
module ddc_front
  import ddc_pkg::*;
#(
  parameter int IN_W  = 14,
  parameter int PH_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic [2:0]              mode,
  input  logic [PH_W-1:0]         freq_word,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int MIX_W = IN_W + 1;

  route_e                  cfg_route;
  logic [PH_W-1:0]         cfg_word;
  logic                    step, hb_evt, late_ok;
  logic signed [MIX_W-1:0] mix_i, mix_q;
  logic signed [OUT_W-1:0] y_i, y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_route <= M_HB;
      cfg_word  <= '0;
    end else if (clear) begin
      cfg_route <= sanitize(mode);
      cfg_word  <= freq_word;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready && !clear;

  ddc_nco_mixer #(.IN_W(IN_W), .PH_W(PH_W), .MIX_W(MIX_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .osc_en(uses_osc(cfg_route)), .word(cfg_word), .x(in_data),
    .mix_i(mix_i), .mix_q(mix_q)
  );

  ddc_hb_decim #(.DW(MIX_W), .OW(OUT_W)) u_hb (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .in_i(mix_i), .in_q(mix_q), .y_i(y_i), .y_q(y_q),
    .hb_evt(hb_evt), .late_ok(late_ok)
  );

  ddc_out_stage #(.OW(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .hb_evt(hb_evt), .late_ok(late_ok),
    .fir_en(uses_fir(cfg_route)), .fs8_en(cfg_route == M_FULL),
    .real_en(is_real(cfg_route)),
    .y_i(y_i), .y_q(y_q), .out_ready(out_ready),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );
endmodule

// File: tb/ddc_front_bench.sv
module ddc_front_bench;
  localparam int PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               clear = 1'b0;
  logic [2:0]         mode = 3'd0;
  logic [31:0]        freq_word = 32'd0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [13:0] in_data = '0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic signed [15:0] out_i, out_q;

  int checks = 0;
  int failures = 0;

  // bench model state
  int          bm;
  bit [31:0]   bw, bacc;
  int          nacc, mrot, fir_i, fir_q, outs_seen;
  int          dl_i[19], dl_q[19];
  int          exp_i[$], exp_q[$], exp_m[$];
  bit          have_prev;
  int          prev_i, prev_q;

  always #(PERIOD/2) clk = ~clk;

  ddc_front u_ddc_front (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode), .freq_word(freq_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  function automatic int coef(int k);
    int d = (k > 9) ? k - 9 : 9 - k;
    case (d)
      0: return 32768;  1: return 20000;  3: return -5400;
      5: return 2300;   7: return -800;   9: return 284;
      default: return 0;
    endcase
  endfunction

  function automatic int hb(int a[19]);
    longint s = 0;
    for (int k = 0; k < 19; k++) s += longint'(coef(k)) * a[k];
    return int'(s >>> 16);
  endfunction

  function automatic bit m_osc(int m); return m == 2 || m == 3 || m == 4; endfunction
  function automatic bit m_fir(int m); return m == 1 || m == 3 || m == 4; endfunction
  function automatic bit m_real(int m); return m == 0 || m == 1 || m == 4; endfunction

  task automatic check(bit ok, string tag, int act, int expv, string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(int si, int sq);
    if (bm == 4) begin
      case (mrot)
        0: exp_i.push_back(si);
        1: exp_i.push_back(-sq);
        2: exp_i.push_back(-si);
        default: exp_i.push_back(sq);
      endcase
      exp_q.push_back(0);
      mrot = (mrot + 1) % 4;
    end else begin
      exp_i.push_back(si);
      exp_q.push_back(m_real(bm) ? 0 : sq);
    end
    exp_m.push_back(bm);
  endtask

  task automatic model_accept(int x);
    int q, mi, mq, yi, yq;
    q = m_osc(bm) ? int'(bacc[31:30]) : 0;
    case (q)
      0: begin mi = x;  mq = 0;  end
      1: begin mi = 0;  mq = -x; end
      2: begin mi = -x; mq = 0;  end
      default: begin mi = 0; mq = x; end
    endcase
    bacc += bw;
    for (int k = 18; k > 0; k--) begin dl_i[k] = dl_i[k-1]; dl_q[k] = dl_q[k-1]; end
    dl_i[0] = mi;
    dl_q[0] = mq;
    nacc++;
    if (nacc >= 19 && (nacc % 2) == 1) begin
      yi = hb(dl_i);
      yq = hb(dl_q);
      if (m_fir(bm)) begin
        if (nacc >= 21) push(fir_i, fir_q);
        fir_i = yi;
        fir_q = yq;
      end else push(yi, yq);
    end
  endtask

  task automatic compare_out();
    int ei, eq, em;
    string tag;
    if (exp_i.size() == 0) begin
      check(1'b0, "R5", 1, 0, "unexpected output");
      return;
    end
    ei = exp_i.pop_front();
    eq = exp_q.pop_front();
    em = exp_m.pop_front();
    tag = (em == 4) ? "R7" : (m_osc(em) ? "R3" : "R4");
    check(int'(out_i) == ei, tag, int'(out_i), ei, "out_i");
    check(int'(out_q) == eq, m_real(em) ? "R8" : tag, int'(out_q), eq, "out_q");
    outs_seen++;
  endtask

  // pulse clear; the model latches the mode (R10: 5..7 act as 0) and word
  task automatic do_clear(int md, bit [31:0] wd);
    @(negedge clk);
    mode = 3'(md);
    freq_word = wd;
    in_valid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check(out_valid == 1'b0, "R1", int'(out_valid), 0, "out_valid after clear");
    bm = (md > 4) ? 0 : md;
    bw = wd;
    bacc = 0; nacc = 0; mrot = 0; fir_i = 0; fir_q = 0; outs_seen = 0;
    for (int k = 0; k < 19; k++) begin dl_i[k] = 0; dl_q[k] = 0; end
    exp_i.delete(); exp_q.delete(); exp_m.delete();
    have_prev = 0;
  endtask

  function automatic int pick_sample();
    int r = int'($urandom % 100);
    if (r < 8) return -8192;
    if (r < 16) return 8191;
    return int'($urandom % 16384) - 8192;
  endfunction

  // feed n samples with given accept probabilities; optional mid-run config poke
  task automatic run_block(int md, bit [31:0] wd, int n, int pv, int pr, bit poke);
    int sent = 0;
    int expn;
    do_clear(md, wd);
    for (int cyc = 0; cyc < 20000 && (sent < n || exp_i.size() > 0 || out_valid); cyc++) begin
      @(negedge clk);
      if (poke && sent == n / 2) begin
        mode = 3'd2;                // R2: not latched without clear
        freq_word = 32'h2000_0000;
      end
      in_valid  = (sent < n) && (int'($urandom % 100) < pv);
      in_data   = 14'(pick_sample());
      out_ready = (sent >= n) || (int'($urandom % 100) < pr);
      #(PERIOD/2 - 1);
      if (have_prev)
        check(out_valid && int'(out_i) == prev_i && int'(out_q) == prev_q, "R9",
              int'(out_i), prev_i, "held under stall");
      have_prev = out_valid && !out_ready;
      prev_i = int'(out_i);
      prev_q = int'(out_q);
      check(in_ready == (!out_valid || out_ready), "R9", int'(in_ready),
            int'(!out_valid || out_ready), "in_ready");
      if (out_valid && out_ready) compare_out();
      if (in_valid && in_ready) begin
        model_accept(int'(in_data));
        sent++;
      end
    end
    in_valid = 1'b0;
    if (m_fir(bm)) begin
      expn = (n >= 21) ? (n - 21) / 2 + 1 : 0;
      check(outs_seen == expn, "R6", outs_seen, expn, "result count");
    end else begin
      expn = (n >= 19) ? (n - 19) / 2 + 1 : 0;
      check(outs_seen == expn, "R5", outs_seen, expn, "result count");
    end
    check(exp_i.size() == 0, poke ? "R2" : "R5", exp_i.size(), 0, "pending results");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0, "out_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0, "out_valid after reset");
    check(in_ready == 1'b1, "R1", int'(in_ready), 1, "in_ready after reset");

    run_block(0, 32'h0,         60,  100, 100, 0);  // R4 plain filter
    run_block(1, 32'h0,         61,  100, 100, 0);  // R6 channel slot
    run_block(2, 32'h4000_0000, 80,  70,  60,  0);  // R3 quarter-rate
    run_block(3, 32'h4000_0000, 80,  80,  50,  0);  // R3 R6
    run_block(4, 32'h4000_0000, 101, 75,  65,  0);  // R7 eighth-rate
    run_block(2, 32'h8000_0000, 50,  90,  70,  0);  // R3 half-rate word
    run_block(2, 32'h1234_5678, 60,  60,  60,  0);  // R3 arbitrary word
    run_block(6, 32'h4000_0000, 45,  80,  80,  0);  // R10
    run_block(4, 32'h4000_0000, 90,  80,  70,  1);  // R2 poke mid-run
    run_block(0, 32'h0,         18,  100, 100, 0);  // R5 just short of fill
    run_block(0, 32'h0,         19,  100, 100, 0);  // R5 first result
    run_block(3, 32'h4000_0000, 20,  100, 100, 0);  // R6 no result yet
    run_block(1, 32'h0,         21,  100, 100, 0);  // R6 first delayed result

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule